// File: doc/BRIEF.md
# Two-Bit Global-History Correlating Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a 1024-entry table of 2-bit saturating counters. Each entry is addressed by eight low word-address bits of the branch PC together with a two-bit record of the outcomes of the last two branches resolved anywhere in the program. Each PC slot therefore holds four counters, one for each recent outcome pattern. Entries carry no tag, so two branches whose low PC bits match share their counters.

The front end presents a PC on the lookup port. In the same cycle it receives the taken/not-taken guess and the history value that the guess used. It keeps that history with the branch. When the branch resolves, the back end returns the PC, the real outcome and the saved history on the training port. That trains exactly one counter and shifts the outcome into the global history. A separate load input overwrites the history, for example after a pipeline flush. The history length is a parameter. A length of zero turns the block into a plain per-PC table of 2-bit counters.

Top module: `gp_predictor`

## Requirements
- R1: After reset, the history register is 00 and every counter holds 01 (weakly not taken), so every lookup returns not taken.
- R2: The table index is {pc[9:2], history}, with the PC bits on the high side. PC bits [1:0] and bits above bit 9 do not affect the index, so PCs that differ only in those bits share counters.
- R3: pred_taken_o is the most significant bit of the counter addressed by pred_pc_i and the current history. It is available in the same cycle, and pred_hist_o shows that history.
- R4: On a training request with outcome taken, the addressed counter increments and stays at 3 if it is already 3.
- R5: On a training request with outcome not taken, the addressed counter decrements and stays at 0 if it is already 0.
- R6: A training request changes only the counter selected by upd_pc_i and upd_hist_i. Every other counter, including the three other history slots of the same PC, keeps its value.
- R7: A training request without a history load makes the next history {old_history[0], outcome}, with the newest outcome in bit 0. With neither request present, the history holds its value.
- R8: A history load sets the history to restore_hist_i on the next cycle. The load takes precedence over the shift from a training request in the same cycle, but that training request still updates its counter.
- R9: When a lookup and a training request address the same counter in one cycle, the lookup returns the value before the update, and the trained value is visible from the next cycle.
- R10: A strongly biased counter (0 or 3) needs two consecutive opposite outcomes before its prediction flips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pred_pc_i | input | 32 | PC of the branch being looked up |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_hist_o | output | 2 | Global history used for this lookup |
| upd_valid_i | input | 1 | Training request strobe |
| upd_pc_i | input | 32 | PC of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome, 1 = taken |
| upd_hist_i | input | 2 | History the branch saw at lookup time |
| restore_valid_i | input | 1 | History load strobe |
| restore_hist_i | input | 2 | Value loaded into the history |

## Verification
A lookup and a training request can land on the same counter in the same cycle. In that case the guess must come from the counter before the update. The bench forces this collision in directed steps, where the lookup PC and the current history match the training PC and history. Random traffic also produces it, because PCs are drawn from a small pool of eight table slots. In every cycle the bench compares the guess with a model that applies training only after the edge. It then reads the same slot on the following cycle to confirm the trained value.

// File: rtl/gp_pkg.sv
package gp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RESET = 2'b01;
  localparam ctr_t CTR_MAX   = 2'b11;
  localparam ctr_t CTR_MIN   = 2'b00;

  function automatic ctr_t ctr_next(ctr_t c, logic taken);
    if (taken) return (c == CTR_MAX) ? CTR_MAX : c + 2'd1;
    else       return (c == CTR_MIN) ? CTR_MIN : c - 2'd1;
  endfunction
endpackage

// File: rtl/gp_index.sv
module gp_index #(
  parameter int PC_W     = 32,
  parameter int PC_IDX_W = 8,
  parameter int HIST_W   = 2,
  localparam int HS_W    = (HIST_W > 0) ? HIST_W : 1,
  localparam int IDX_W   = PC_IDX_W + HIST_W
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [HS_W-1:0]  hist_i,
  output logic [IDX_W-1:0] idx_o
);
  logic unused_pc_bits;
  assign unused_pc_bits = ^{pc_i[PC_W-1:PC_IDX_W+2], pc_i[1:0]};

  generate
    if (HIST_W == 0) begin : g_no_hist
      logic unused_hist;
      assign unused_hist = ^hist_i;
      assign idx_o = pc_i[PC_IDX_W+1:2];
    end else begin : g_hist
      // word-address bits high, history low
      assign idx_o = {pc_i[PC_IDX_W+1:2], hist_i};
    end
  endgenerate
endmodule

// File: rtl/gp_hist_reg.sv
module gp_hist_reg #(
  parameter int HIST_W = 2,
  localparam int HS_W  = (HIST_W > 0) ? HIST_W : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            shift_i,
  input  logic            taken_i,
  input  logic            load_i,
  input  logic [HS_W-1:0] load_val_i,
  output logic [HS_W-1:0] hist_o
);
  generate
    if (HIST_W == 0) begin : g_none
      logic unused_in;
      assign unused_in = ^{clk_i, rst_ni, shift_i, taken_i, load_i, load_val_i};
      assign hist_o = '0;
    end else begin : g_reg
      logic [HS_W-1:0] hist_q;
      logic [HS_W-1:0] hist_shift;

      if (HIST_W == 1) begin : g_one
        assign hist_shift = taken_i;
      end else begin : g_many
        assign hist_shift = {hist_q[HS_W-2:0], taken_i};
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      hist_q <= '0;
        else if (load_i)  hist_q <= load_val_i;
        else if (shift_i) hist_q <= hist_shift;
      end
      assign hist_o = hist_q;
    end
  endgenerate
endmodule

// File: rtl/gp_ctr_table.sv
module gp_ctr_table
  import gp_pkg::*;
#(
  parameter int IDX_W = 10,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output ctr_t             rd_ctr_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_taken_i,
  output ctr_t             wr_ctr_o
);
  ctr_t tbl_q [DEPTH];

  assign rd_ctr_o = tbl_q[rd_idx_i];
  assign wr_ctr_o = tbl_q[wr_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) tbl_q[i] <= CTR_RESET;
    end else if (wr_en_i) begin
      tbl_q[wr_idx_i] <= ctr_next(wr_ctr_o, wr_taken_i);
    end
  end
endmodule

// File: rtl/gp_predictor.sv
module gp_predictor
  import gp_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int PC_IDX_W = 8,
  parameter int HIST_W   = 2,
  localparam int HS_W    = (HIST_W > 0) ? HIST_W : 1,
  localparam int IDX_W   = PC_IDX_W + HIST_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] pred_pc_i,
  output logic            pred_taken_o,
  output logic [HS_W-1:0] pred_hist_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic [HS_W-1:0] upd_hist_i,
  input  logic            restore_valid_i,
  input  logic [HS_W-1:0] restore_hist_i
);
  logic [HS_W-1:0]  ghist;
  logic [IDX_W-1:0] pred_idx;
  logic [IDX_W-1:0] upd_idx;
  ctr_t             rd_ctr;
  ctr_t             wr_ctr;

  gp_hist_reg #(.HIST_W(HIST_W)) u_hist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_i    (upd_valid_i),
    .taken_i    (upd_taken_i),
    .load_i     (restore_valid_i),
    .load_val_i (restore_hist_i),
    .hist_o     (ghist)
  );

  gp_index #(.PC_W(PC_W), .PC_IDX_W(PC_IDX_W), .HIST_W(HIST_W)) u_pred_idx (
    .pc_i   (pred_pc_i),
    .hist_i (ghist),
    .idx_o  (pred_idx)
  );

  gp_index #(.PC_W(PC_W), .PC_IDX_W(PC_IDX_W), .HIST_W(HIST_W)) u_upd_idx (
    .pc_i   (upd_pc_i),
    .hist_i (upd_hist_i),
    .idx_o  (upd_idx)
  );

  gp_ctr_table #(.IDX_W(IDX_W)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (pred_idx),
    .rd_ctr_o   (rd_ctr),
    .wr_en_i    (upd_valid_i),
    .wr_idx_i   (upd_idx),
    .wr_taken_i (upd_taken_i),
    .wr_ctr_o   (wr_ctr)
  );

  assign pred_taken_o = rd_ctr[1];
  assign pred_hist_o  = ghist;
endmodule

// File: rtl/gp_predictor_chk.sv
module gp_predictor_chk
  import gp_pkg::*;
#(
  parameter int HS_W  = 2,
  parameter int IDX_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [HS_W-1:0]  pred_hist_o,
  input logic             upd_valid_i,
  input logic             upd_taken_i,
  input logic             restore_valid_i,
  input logic [HS_W-1:0]  restore_hist_i,
  input logic [IDX_W-1:0] pred_idx,
  input logic [IDX_W-1:0] upd_idx,
  input ctr_t             rd_ctr,
  input ctr_t             wr_ctr
);
  a_r7_hist_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && !restore_valid_i |=>
      pred_hist_o == HS_W'({$past(pred_hist_o), $past(upd_taken_i)}));

  a_r7_hist_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i && !restore_valid_i |=> $stable(pred_hist_o));

  a_r8_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_valid_i |=> pred_hist_o == $past(restore_hist_i));

  a_r4_train_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(upd_valid_i) && $past(upd_taken_i) && pred_idx == $past(upd_idx) |->
      rd_ctr == (($past(wr_ctr) == 2'd3) ? 2'd3 : $past(wr_ctr) + 2'd1));

  a_r5_train_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(upd_valid_i) && !$past(upd_taken_i) && pred_idx == $past(upd_idx) |->
      rd_ctr == (($past(wr_ctr) == 2'd0) ? 2'd0 : $past(wr_ctr) - 2'd1));
endmodule

bind gp_predictor gp_predictor_chk #(.HS_W(HS_W), .IDX_W(IDX_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .pred_hist_o     (pred_hist_o),
  .upd_valid_i     (upd_valid_i),
  .upd_taken_i     (upd_taken_i),
  .restore_valid_i (restore_valid_i),
  .restore_hist_i  (restore_hist_i),
  .pred_idx        (pred_idx),
  .upd_idx         (upd_idx),
  .rd_ctr          (rd_ctr),
  .wr_ctr          (wr_ctr)
);

// File: tb/sim_gp_predictor.sv
module sim_gp_predictor;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pred_pc_i = '0;
  logic        pred_taken_o;
  logic [1:0]  pred_hist_o;
  logic        upd_valid_i = 1'b0;
  logic [31:0] upd_pc_i = '0;
  logic        upd_taken_i = 1'b0;
  logic [1:0]  upd_hist_i = '0;
  logic        restore_valid_i = 1'b0;
  logic [1:0]  restore_hist_i = '0;

  int n_checks = 0;
  int n_fails  = 0;
  int model [1024];
  logic [1:0] mhist;

  always #4 clk = ~clk;

  gp_predictor u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .pred_pc_i(pred_pc_i), .pred_taken_o(pred_taken_o), .pred_hist_o(pred_hist_o),
    .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i), .upd_taken_i(upd_taken_i),
    .upd_hist_i(upd_hist_i), .restore_valid_i(restore_valid_i),
    .restore_hist_i(restore_hist_i)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive, compare lookup against model, then apply model update
  task automatic step(input string tag, input logic [31:0] ppc,
                      input logic uv, input logic [31:0] upc, input logic ut,
                      input logic [1:0] uh, input logic rv, input logic [1:0] rh);
    int idx;
    int ui;
    @(negedge clk);
    pred_pc_i = ppc; upd_valid_i = uv; upd_pc_i = upc; upd_taken_i = ut;
    upd_hist_i = uh; restore_valid_i = rv; restore_hist_i = rh;
    #1;
    idx = {ppc[9:2], mhist};
    check({tag, " pred"}, int'(pred_taken_o), (model[idx] >= 2) ? 1 : 0);
    check({tag, " hist"}, int'(pred_hist_o), int'(mhist));
    @(posedge clk);
    if (uv) begin
      ui = {upc[9:2], uh};
      if (ut) model[ui] = (model[ui] == 3) ? 3 : model[ui] + 1;
      else    model[ui] = (model[ui] == 0) ? 0 : model[ui] - 1;
    end
    if (rv)      mhist = rh;
    else if (uv) mhist = {mhist[0], ut};
  endtask

  task automatic idle_pred(input string tag, input logic [31:0] ppc, input logic [1:0] h);
    step(tag, ppc, 1'b0, '0, 1'b0, 2'b00, 1'b1, h);
  endtask

  initial begin
    #(8 * 150000);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [31:0] pa;
    for (int i = 0; i < 1024; i++) model[i] = 1;
    mhist = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R1: reset state of history and every counter (sweep uses R8 loads)
    #1;
    check("R1 hist after reset", int'(pred_hist_o), 0);
    for (int h = 0; h < 4; h++) begin
      idle_pred("R8 load", 32'h0, 2'(h));
      for (int p = 0; p < 256; p++) begin
        idle_pred("R1 reset sweep", {22'h0, 8'(p), 2'b00}, 2'(h));
        check("R1 not taken", int'(pred_taken_o), 0);
      end
    end

    // R4 / R10: train up to saturation with history held at 00
    pa = 32'h0000_0040;
    idle_pred("R8 load", pa, 2'b00);
    for (int k = 0; k < 4; k++) step("R4 inc", pa, 1'b1, pa, 1'b1, 2'b00, 1'b1, 2'b00);
    idle_pred("R4 saturated", pa, 2'b00);
    check("R4 counter at 3 predicts taken", int'(pred_taken_o), 1);
    // R10: one opposite outcome keeps taken, the second flips
    step("R10 first miss", pa, 1'b1, pa, 1'b0, 2'b00, 1'b1, 2'b00);
    idle_pred("R10 after one miss", pa, 2'b00);
    check("R10 still taken", int'(pred_taken_o), 1);
    step("R10 second miss", pa, 1'b1, pa, 1'b0, 2'b00, 1'b1, 2'b00);
    idle_pred("R10 after two misses", pa, 2'b00);
    check("R10 flipped", int'(pred_taken_o), 0);

    // R5: drive to floor and beyond
    for (int k = 0; k < 4; k++) step("R5 dec", pa, 1'b1, pa, 1'b0, 2'b00, 1'b1, 2'b00);
    step("R5 at floor", pa, 1'b1, pa, 1'b1, 2'b00, 1'b1, 2'b00);
    idle_pred("R5 one up from 0", pa, 2'b00);
    check("R5 counter 1 predicts not taken", int'(pred_taken_o), 0);

    // R6: other history slots of the same PC untouched
    for (int h = 1; h < 4; h++) begin
      idle_pred("R6 neighbour", pa, 2'(h));
      check("R6 neighbour still reset", int'(pred_taken_o), 0);
    end

    // R2: aliasing through ignored PC bits
    step("R2 train", pa, 1'b1, pa, 1'b1, 2'b00, 1'b1, 2'b00);
    step("R2 train", pa, 1'b1, pa, 1'b1, 2'b00, 1'b1, 2'b00);
    idle_pred("R2 alias high bits", pa | 32'hABCD_0000, 2'b00);
    check("R2 alias high", int'(pred_taken_o), 1);
    idle_pred("R2 alias low bits", pa | 32'h3, 2'b00);
    check("R2 alias low", int'(pred_taken_o), 1);

    // R9: same-cycle lookup and training of one counter
    pa = 32'h0000_0100;
    step("R9 collide", pa, 1'b1, pa, 1'b1, 2'b00, 1'b1, 2'b00);
    check("R9 pre-update value", int'(pred_taken_o), 0);
    idle_pred("R9 after", pa, 2'b00);
    check("R9 post-update value", int'(pred_taken_o), 1);

    // R7 / R8: shift, hold and load precedence
    idle_pred("R8 load 10", pa, 2'b10);
    step("R7 shift", pa, 1'b1, 32'h0000_0800, 1'b1, 2'b00, 1'b0, 2'b00);
    #1; check("R7 shifted history", int'(pred_hist_o), 1);
    step("R7 hold", pa, 1'b0, '0, 1'b0, 2'b00, 1'b0, 2'b00);
    #1; check("R7 held history", int'(pred_hist_o), 1);
    step("R8 load beats shift", pa, 1'b1, 32'h0000_0800, 1'b1, 2'b00, 1'b1, 2'b10);
    #1; check("R8 loaded history", int'(pred_hist_o), 2);

    // R3 / R6 / R7 / R9: mixed traffic over a small PC pool
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] ppc;
      logic [31:0] upc;
      ppc = ($urandom & 32'hFFFF_FC03) | (($urandom % 8) << 2);
      upc = (($urandom % 3) == 0) ? ppc : (($urandom & 32'hFFFF_FC03) | (($urandom % 8) << 2));
      step("R3 R6 R7 random", ppc, ($urandom % 4) != 0, upc, $urandom % 2,
           2'($urandom % 4), ($urandom % 8) == 0, 2'($urandom % 4));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule